// File: doc/BRIEF.md
# Rank Chip-Select Resolver with Spare Redirect

This block decides which memory rank (chip select) inside a channel owns a channel-normalized address. Every rank has a base register and each pair of ranks shares a mask register. The requester presents an address and a channel number, with a one-cycle strobe. One cycle later the block returns the number of the lowest-numbered enabled rank that claims the address. If no rank claims it, the block returns a miss flag instead.

A single spare-control word records, per channel, whether a failed rank has already been copied onto a spare rank. When that copy is marked complete and the lookup lands on the failed rank, the answer becomes the lowest-numbered rank in the same bank whose spare bit is set. Each channel owns its own bank of base and mask registers. A gang request always searches the bank of channel 0. The swap state is still taken from the requested channel.

Top module: `cs_rank_resolver`

## Requirements
- R1: A rank can only claim an address when bit 0 (enable) of its base register is 1.
- R2: Let F be the field mask (default 0x1FF83FE0), A the address bits [39:8], B the base register and M the mask register. Rank k claims the address when (A & F & ~(M & F)) equals (B & F & ~(M & F)).
- R3: Rank k is compared using mask register k/2 (integer division), so ranks 2j and 2j+1 share mask register j.
- R4: When several ranks claim the address, the lowest-numbered one is reported.
- R5: In the spare-control word, bit 1+2c is the swap-done flag for channel c, and bits [6+4c:4+4c] hold the failed rank for channel c. When swap-done is set and the reported rank equals the failed rank, the result becomes the lowest-numbered rank in the searched bank whose base bit 1 (spare) is set.
- R6: The claimed rank is reported unchanged in three cases: swap-done is clear, the claimed rank differs from the failed rank, or no rank in the bank has its spare bit set.
- R7: When no rank claims the address, the result has miss=1, found=0 and chip select 0. When a rank does claim it, the result has found=1 and miss=0.
- R8: rsp_valid is high exactly in the cycle after a cycle with req_valid high. When it is low, found and miss are both 0.
- R9: A request searches the bank of req_chan when req_gang=0, and the bank of channel 0 when req_gang=1. The swap state always comes from req_chan.
- R10: Reset clears every base, mask and spare-control register and every result output.
- R11: A write with wr_en=1 updates one register, chosen by wr_kind: 0 selects base[wr_chan][wr_idx], 1 selects mask[wr_chan][wr_idx mod 4], 2 selects the spare-control word. Kind 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register class: 0 base, 1 mask, 2 spare control, 3 none |
| wr_chan | input | 1 | Channel bank for base and mask writes |
| wr_idx | input | 3 | Rank index (base) or mask index (mask) |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 40 | Channel-normalized address |
| req_chan | input | 1 | Requested channel |
| req_gang | input | 1 | Gang request: search channel 0 bank |
| rsp_valid | output | 1 | Result valid, one cycle after req_valid |
| rsp_cs | output | 3 | Resolved chip select |
| rsp_found | output | 1 | A rank claimed the address |
| rsp_miss | output | 1 | No rank claimed the address |

## Verification
A corrupted base or mask register, or a wrong bank select, shows up on the very next lookup that touches the affected address region. It appears one cycle after the strobe, as a wrong rsp_cs or a swapped found/miss pair. An error in the spare redirect appears only for addresses that land on the failed rank of a channel whose swap is marked done. The sweeps therefore hit every region on both channels with the swap flags both on and off. A fault in priority only appears where ranks overlap, so one configuration deliberately makes several ranks claim the same region.

// File: rtl/cs_match_pkg.sv
package cs_match_pkg;

  typedef enum logic [1:0] {
    WK_BASE  = 2'd0,
    WK_MASK  = 2'd1,
    WK_SPARE = 2'd2,
    WK_NONE  = 2'd3
  } wr_kind_e;

  // Masked equality in the register domain: enable bit plus field compare.
  function automatic logic rank_claims(input logic [31:0] addr_field,
                                       input logic [31:0] base,
                                       input logic [31:0] mask,
                                       input logic [31:0] fmask);
    logic [31:0] care;
    care = fmask & ~(mask & fmask);
    return base[0] && ((addr_field & care) == (base & care));
  endfunction

endpackage

// File: rtl/cs_bank_regs.sv
module cs_bank_regs #(
  parameter int NUM_CS = 8,
  parameter int NUM_CH = 2,
  parameter int REG_W  = 32,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int MK_N  = NUM_CS / 2,
  localparam int MK_W  = $clog2(MK_N)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_kind,
  input  logic [CH_W-1:0]               wr_chan,
  input  logic [CS_W-1:0]               wr_idx,
  input  logic [REG_W-1:0]              wr_data,
  input  logic [CH_W-1:0]               rd_bank,
  output logic [NUM_CS-1:0][REG_W-1:0]  bank_base,
  output logic [MK_N-1:0][REG_W-1:0]    bank_mask,
  output logic [REG_W-1:0]              spare_word
);
  import cs_match_pkg::*;

  logic [NUM_CS-1:0][REG_W-1:0] base_q [NUM_CH];
  logic [MK_N-1:0][REG_W-1:0]   mask_q [NUM_CH];
  logic [REG_W-1:0]             spare_q;

  wr_kind_e kind;
  assign kind = wr_kind_e'(wr_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        base_q[c] <= '0;
        mask_q[c] <= '0;
      end
      spare_q <= '0;
    end else if (wr_en) begin
      case (kind)
        WK_BASE:  base_q[wr_chan][wr_idx]             <= wr_data;
        WK_MASK:  mask_q[wr_chan][wr_idx[MK_W-1:0]]   <= wr_data;
        WK_SPARE: spare_q                             <= wr_data;
        default:  ;
      endcase
    end
  end

  assign bank_base  = base_q[rd_bank];
  assign bank_mask  = mask_q[rd_bank];
  assign spare_word = spare_q;

endmodule

// File: rtl/cs_hit_encoder.sv
module cs_hit_encoder #(
  parameter int          NUM_CS     = 8,
  parameter int          REG_W      = 32,
  parameter logic [31:0] FIELD_MASK = 32'h1FF83FE0,
  localparam int CS_W = $clog2(NUM_CS),
  localparam int MK_N = NUM_CS / 2
) (
  input  logic [REG_W-1:0]              addr_field,
  input  logic [NUM_CS-1:0][REG_W-1:0]  bank_base,
  input  logic [MK_N-1:0][REG_W-1:0]    bank_mask,
  output logic [NUM_CS-1:0]             hit_vec,
  output logic [NUM_CS-1:0]             spare_vec,
  output logic                          hit_any,
  output logic [CS_W-1:0]               hit_idx,
  output logic                          spare_any,
  output logic [CS_W-1:0]               spare_idx
);
  import cs_match_pkg::*;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_rank
    assign hit_vec[k]   = rank_claims(addr_field, bank_base[k], bank_mask[k/2], FIELD_MASK);
    assign spare_vec[k] = bank_base[k][1];
  end

  always_comb begin
    hit_idx   = '0;
    spare_idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_vec[i])   hit_idx   = CS_W'(i);
      if (spare_vec[i]) spare_idx = CS_W'(i);
    end
  end

  assign hit_any   = |hit_vec;
  assign spare_any = |spare_vec;

endmodule

// File: rtl/cs_spare_swap.sv
module cs_spare_swap #(
  parameter int NUM_CH = 2,
  parameter int CS_W   = 3,
  parameter int REG_W  = 32,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int FAIL_W = 3
) (
  input  logic [REG_W-1:0] spare_word,
  input  logic [CH_W-1:0]  chan,
  input  logic             hit_any,
  input  logic [CS_W-1:0]  hit_idx,
  input  logic             spare_any,
  input  logic [CS_W-1:0]  spare_idx,
  output logic             swap_taken,
  output logic [CS_W-1:0]  final_idx
);
  logic [NUM_CH-1:0]  done_v;
  logic [FAIL_W-1:0]  fail_v [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign done_v[c] = spare_word[1 + 2*c];
    assign fail_v[c] = spare_word[4 + 4*c +: FAIL_W];
  end

  logic              done_sel;
  logic [FAIL_W-1:0] fail_sel;
  assign done_sel = done_v[chan];
  assign fail_sel = fail_v[chan];

  assign swap_taken = done_sel && hit_any && spare_any && (hit_idx == CS_W'(fail_sel));
  assign final_idx  = swap_taken ? spare_idx : hit_idx;

endmodule

// File: rtl/cs_rank_resolver.sv
module cs_rank_resolver #(
  parameter int          NUM_CS     = 8,
  parameter int          NUM_CH     = 2,
  parameter int          ADDR_W     = 40,
  parameter int          REG_W      = 32,
  parameter logic [31:0] FIELD_MASK = 32'h1FF83FE0,
  localparam int CS_W = $clog2(NUM_CS),
  localparam int CH_W = $clog2(NUM_CH),
  localparam int MK_N = NUM_CS / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [CS_W-1:0]   wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CH_W-1:0]   req_chan,
  input  logic              req_gang,
  output logic              rsp_valid,
  output logic [CS_W-1:0]   rsp_cs,
  output logic              rsp_found,
  output logic              rsp_miss
);
  logic [CH_W-1:0]              rd_bank;
  logic [NUM_CS-1:0][REG_W-1:0] bank_base;
  logic [MK_N-1:0][REG_W-1:0]   bank_mask;
  logic [REG_W-1:0]             spare_word;
  logic [REG_W-1:0]             addr_field;

  logic [NUM_CS-1:0] hit_vec;
  logic [NUM_CS-1:0] spare_vec;
  logic              hit_any;
  logic [CS_W-1:0]   hit_idx;
  logic              spare_any;
  logic [CS_W-1:0]   spare_idx;
  logic              swap_taken;
  logic [CS_W-1:0]   final_idx;

  assign rd_bank    = req_gang ? '0 : req_chan;
  assign addr_field = REG_W'(req_addr >> 8);

  cs_bank_regs #(.NUM_CS(NUM_CS), .NUM_CH(NUM_CH), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_kind    (wr_kind),
    .wr_chan    (wr_chan),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_bank    (rd_bank),
    .bank_base  (bank_base),
    .bank_mask  (bank_mask),
    .spare_word (spare_word)
  );

  cs_hit_encoder #(.NUM_CS(NUM_CS), .REG_W(REG_W), .FIELD_MASK(FIELD_MASK)) u_enc (
    .addr_field (addr_field),
    .bank_base  (bank_base),
    .bank_mask  (bank_mask),
    .hit_vec    (hit_vec),
    .spare_vec  (spare_vec),
    .hit_any    (hit_any),
    .hit_idx    (hit_idx),
    .spare_any  (spare_any),
    .spare_idx  (spare_idx)
  );

  cs_spare_swap #(.NUM_CH(NUM_CH), .CS_W(CS_W), .REG_W(REG_W)) u_swap (
    .spare_word (spare_word),
    .chan       (req_chan),
    .hit_any    (hit_any),
    .hit_idx    (hit_idx),
    .spare_any  (spare_any),
    .spare_idx  (spare_idx),
    .swap_taken (swap_taken),
    .final_idx  (final_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_cs    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_found <= req_valid && hit_any;
      rsp_miss  <= req_valid && !hit_any;
      rsp_cs    <= (req_valid && hit_any) ? final_idx : '0;
    end
  end

endmodule

// File: rtl/cs_rank_resolver_chk.sv
module cs_rank_resolver_chk #(
  parameter int NUM_CS = 8,
  parameter int CS_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_found,
  input logic              rsp_miss,
  input logic [CS_W-1:0]   rsp_cs,
  input logic [NUM_CS-1:0] hit_vec,
  input logic              hit_any,
  input logic [CS_W-1:0]   hit_idx,
  input logic [NUM_CS-1:0] spare_vec,
  input logic              swap_taken,
  input logic [CS_W-1:0]   final_idx
);
  logic [NUM_CS-1:0] below_hit;
  logic [NUM_CS-1:0] below_final;

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) begin
      below_hit[i]   = (CS_W'(i) < hit_idx);
      below_final[i] = (CS_W'(i) < final_idx);
    end
  end

  // R4: reported rank claims the address and no lower rank does
  a_r4_lowest_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (hit_vec[hit_idx] && ((hit_vec & below_hit) == '0)));

  // R5: a redirect lands on the lowest rank flagged as spare
  a_r5_redirect_to_spare: assert property (@(posedge clk) disable iff (!rst_n)
    swap_taken |-> (spare_vec[final_idx] && ((spare_vec & below_final) == '0)));

  // R2: registered found flag reflects the compare of the strobed cycle
  a_r2_found_tracks_hit: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_found == $past(hit_any)));

  // R7: found and miss are exclusive for a valid result, miss reports rank 0
  a_r7_found_or_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_found ^ rsp_miss));

  a_r7_miss_cs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_cs == '0));

  // R8: one-cycle latency and quiet outputs otherwise
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_found && !rsp_miss));

endmodule

bind cs_rank_resolver cs_rank_resolver_chk #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_found  (rsp_found),
  .rsp_miss   (rsp_miss),
  .rsp_cs     (rsp_cs),
  .hit_vec    (hit_vec),
  .hit_any    (hit_any),
  .hit_idx    (hit_idx),
  .spare_vec  (spare_vec),
  .swap_taken (swap_taken),
  .final_idx  (final_idx)
);

// File: tb/test_cs_rank_resolver.sv
`timescale 1ns/1ps
module test_cs_rank_resolver;
  localparam logic [31:0] FM = 32'h1FF83FE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = 2'd0;
  logic        wr_chan = 1'b0;
  logic [2:0]  wr_idx = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic        req_valid = 1'b0;
  logic [39:0] req_addr = 40'd0;
  logic        req_chan = 1'b0;
  logic        req_gang = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_cs;
  logic        rsp_found;
  logic        rsp_miss;

  always #2 clk = ~clk;

  cs_rank_resolver i_cs_rank_resolver (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_chan(wr_chan),
    .wr_idx(wr_idx), .wr_data(wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .req_chan(req_chan), .req_gang(req_gang), .rsp_valid(rsp_valid), .rsp_cs(rsp_cs),
    .rsp_found(rsp_found), .rsp_miss(rsp_miss)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_base [2][8];
  logic [31:0] m_mask [2][4];
  logic [31:0] m_spare;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input int ch, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_chan = ch[0]; wr_idx = idx[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (kind)
      2'd0: m_base[ch][idx] = d;
      2'd1: m_mask[ch][idx % 4] = d;
      2'd2: m_spare = d;
      default: ;
    endcase
  endtask

  // Shifted 40-bit comparison form of the claim rule
  function automatic bit m_hit(input logic [39:0] a, input logic [31:0] b, input logic [31:0] mk);
    logic [39:0] ia, bs, ms;
    ia = {a[39:8] & FM, 8'h00};
    bs = {b & FM, 8'h00};
    ms = {mk & FM, 8'h00};
    return b[0] && ((ia & ~ms) == (bs & ~ms));
  endfunction

  task automatic predict(input logic [39:0] a, input int ch, input bit gang,
                         output bit found, output int cs);
    int bank;
    int fr;
    bit done;
    bank = gang ? 0 : ch;
    found = 1'b0;
    cs = 0;
    for (int k = 0; k < 8; k++)
      if (!found && m_hit(a, m_base[bank][k], m_mask[bank][k / 2])) begin
        found = 1'b1; cs = k;
      end
    done = m_spare[1 + 2 * ch];
    fr = int'((m_spare >> (4 + 4 * ch)) & 32'h7);
    if (found && done && cs == fr) begin
      for (int k = 7; k >= 0; k--)
        if (m_base[bank][k][1]) cs = k;
    end
  endtask

  task automatic lookup(input logic [39:0] a, input int ch, input bit gang, input string tag);
    bit ef;
    int ecs;
    predict(a, ch, gang, ef, ecs);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_chan = ch[0]; req_gang = gang;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(tag, "rsp_found", 32'(rsp_found), 32'(ef));
    chk(ef ? tag : "R7", "rsp_miss", 32'(rsp_miss), 32'(!ef));
    chk(tag, "rsp_cs", 32'(rsp_cs), ef ? 32'(ecs) : 32'd0);
    @(negedge clk);
    chk("R8", "idle valid/found/miss", {29'd0, rsp_valid, rsp_found, rsp_miss}, 32'd0);
  endtask

  function automatic logic [39:0] sweep_addr(input int i);
    return (40'(i & 7) << 27) | (40'((i >> 3) & 31) << 14) | 40'((i * 37) & 255);
  endfunction

  task automatic sweep(input int ch, input bit gang, input string tag);
    for (int i = 0; i < 256; i++) lookup(sweep_addr(i), ch, gang, tag);
  endtask

  task automatic structured();
    for (int k = 0; k < 8; k++) begin
      wr(2'd0, 0, k, (32'(k) << 19) | 32'd1);
      wr(2'd0, 1, k, (k < 6) ? ((32'(7 - k) << 19) | 32'd1) : 32'd0);
    end
    for (int j = 0; j < 4; j++) begin
      wr(2'd1, 0, j, 32'h00003FE0);
      wr(2'd1, 1, j, 32'h00003FE0);
    end
    wr(2'd2, 0, 0, 32'd0);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 8; k++) m_base[c][k] = 32'd0;
      for (int j = 0; j < 4; j++) m_mask[c][j] = 32'd0;
    end
    m_spare = 32'd0;
    repeat (3) @(negedge clk);
    // R10: outputs after reset
    chk("R10", "reset outputs", {28'd0, rsp_valid, rsp_found, rsp_miss, rsp_cs != 3'd0}, 32'd0);
    rst_n = 1'b1;
    // R10/R7: cleared registers miss everywhere
    for (int i = 0; i < 64; i++) lookup(sweep_addr(i * 4), i % 2, 1'b0, "R10");

    // R2, R9: distinct banks per channel, gang uses channel 0 bank
    structured();
    sweep(0, 1'b0, "R2");
    sweep(1, 1'b0, "R9");
    sweep(1, 1'b1, "R9");

    // R11: kind 3 write is a no-op
    wr(2'd3, 0, 3, 32'hFFFF_FFFF);
    sweep(0, 1'b0, "R11");

    // R1, R4: overlapping ranks, lowest one disabled
    for (int k = 0; k < 8; k++) wr(2'd0, 0, k, (32'd2 << 19) | (k == 0 ? 32'd0 : 32'd1));
    sweep(0, 1'b0, "R4");
    lookup(40'd2 << 27, 0, 1'b0, "R1");

    // R3: shared wide mask on pair 2/3
    structured();
    wr(2'd1, 0, 1, 32'h00383FE0);
    wr(2'd0, 0, 2, (32'd5 << 19) | 32'd1);
    sweep(0, 1'b0, "R3");

    // R5: swap done on both channels
    structured();
    wr(2'd0, 0, 6, m_base[0][6] | 32'd2);
    wr(2'd0, 0, 7, m_base[0][7] | 32'd2);
    wr(2'd0, 1, 6, 32'd2);
    wr(2'd2, 0, 0, 32'd2 | (32'd3 << 4) | 32'd8 | (32'd5 << 8));
    sweep(0, 1'b0, "R5");
    sweep(1, 1'b0, "R5");
    lookup(40'd3 << 27, 0, 1'b0, "R5");

    // R6: failed ranks recorded but swap not done
    wr(2'd2, 0, 0, (32'd3 << 4) | (32'd5 << 8));
    sweep(0, 1'b0, "R6");
    sweep(1, 1'b0, "R6");
    // R6: swap done but no spare bits in the bank
    structured();
    wr(2'd2, 0, 0, 32'd2 | (32'd4 << 4));
    sweep(0, 1'b0, "R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule